// File: doc/BRIEF.md
# Phase-Offset Pulse Generator

This block produces a periodic rectangular pulse. Two programmable counts place it inside a repeating frame: one sets where the output rises and the other sets where it falls. The pulse can therefore be moved in phase within the frame, as well as made wider or narrower. A frame counter defines the frame and advances only on cycles where an external prescaler enable is high. A separate one-cycle marker on its own output flags the start of each frame, so an oscilloscope or a neighbouring block can lock onto the frame instead of onto the pulse.

By default a frame lasts 2^CNT_W counts. An optional frame limit ends the frame early, which allows exact ratios such as one fifth. The host presents the rise count, the fall count, the limit and the limit-enable together with a write strobe. These values are captured into a holding set, which becomes active only when the frame ends. A width or phase change can therefore never produce a runt or a stretched pulse.

Top module: `phase_pwm`

## Requirements
- R1: The frame counter advances by one only on clock cycles where `tick_en` is 1. On other cycles it holds its value. Without a limit it runs 0, 1, ..., 2^CNT_W-1 and then returns to 0, so a default frame is 256 ticks long.
- R2: When the active rise count is below the active fall count, `pwm_out` is 1 exactly for counter values in the range from the rise count up to, but not including, the fall count. The output is registered, so it shows the value for a counter state one clock after the counter holds that state.
- R3: When the active fall count is below the active rise count, the pulse spans the frame boundary. `pwm_out` is 1 for counter values at or above the rise count and for counter values below the fall count, with the same one-clock delay.
- R4: When the active rise count equals the active fall count, `pwm_out` stays 0 for the whole frame.
- R5: `frame_sync` is 1 for exactly one clock, namely the clock after a tick that returns the counter to 0. It is 0 at all other times.
- R6: When the active limit-enable is 1, the counter returns to 0 on the tick after it reaches the active limit value, so a frame lasts limit+1 ticks. For example, a limit of 4 with rise 0 and fall 1 gives a duty of exactly 1 in 5.
- R7: A write on `wr_en` is held and becomes active at the first frame end after the write cycle. A write made in the same cycle as the frame-ending tick waits for the following frame end. Until it becomes active, the output keeps its previous shape.
- R8: While `rst_n` is 0 on a clock edge, the counter, `pwm_out` and `frame_sync` clear to 0. The active and held settings load rise 0x32, fall 0x64, limit 0xFF and limit disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Prescaler enable; the counter advances on cycles where it is 1 |
| wr_en | input | 1 | Captures the four setting inputs into the holding set |
| rise_cnt | input | CNT_W | Counter value at which the pulse rises |
| fall_cnt | input | CNT_W | Counter value at which the pulse falls |
| limit_cnt | input | CNT_W | Last counter value of a frame when the limit is enabled |
| limit_en | input | 1 | Enables the frame limit |
| pwm_out | output | 1 | Registered pulse output |
| frame_sync | output | 1 | One-clock marker at the start of each frame |

## Verification
The hardest case to reach from the ports is a setting write that lands on the very cycle of the frame-ending tick. The held value must then skip that boundary and wait a full frame. The bench keeps its own model of the counter, so it knows the exact cycle on which the limit is reached. It issues writes on that cycle, on gated-tick cycles and in mid-frame. It also sweeps every rise/fall pair on a ten-count frame, which covers all three pulse shapes and the changes between them.

// File: rtl/phase_pwm_pkg.sv
// Package: shared constants and the pulse-shape classification for the
// phase-offset pulse generator. Assumes counts are unsigned.
package phase_pwm_pkg;

    // Shape of the pulse inside one frame, decided from the active counts.
    typedef enum logic [1:0] {
        SHAPE_NONE  = 2'd0,   // rise == fall: output held low
        SHAPE_INNER = 2'd1,   // rise <  fall: pulse inside the frame
        SHAPE_SPAN  = 2'd2    // rise >  fall: pulse crosses frame end
    } pulse_shape_e;

    localparam int DEF_CNT_W    = 8;
    localparam int DEF_RISE_RST = 'h32;
    localparam int DEF_FALL_RST = 'h64;

endpackage

// File: rtl/pwm_cfg_bank.sv
// Module: pwm_cfg_bank
// Holds the double-buffered settings. A host write fills the holding set;
// the active set copies the holding set on the frame-ending tick.
// Assumes frame_end is high for one cycle per frame. When HAS_LIMIT is 0
// the limit registers are not built and the frame is always full length.
module pwm_cfg_bank #(
    parameter int CNT_W     = 8,
    parameter int HAS_LIMIT = 1,
    parameter int RISE_RST  = 'h32,
    parameter int FALL_RST  = 'h64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] rise_in,
    input  logic [CNT_W-1:0] fall_in,
    input  logic [CNT_W-1:0] limit_in,
    input  logic             limit_en_in,
    input  logic             frame_end,
    output logic [CNT_W-1:0] act_rise,
    output logic [CNT_W-1:0] act_fall,
    output logic [CNT_W-1:0] act_limit,
    output logic             act_limit_en
);

    localparam logic [CNT_W-1:0] RISE_INIT = CNT_W'(RISE_RST);
    localparam logic [CNT_W-1:0] FALL_INIT = CNT_W'(FALL_RST);
    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

    logic [CNT_W-1:0] hold_rise;
    logic [CNT_W-1:0] hold_fall;

    // Capture host writes into the holding edge counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_rise <= RISE_INIT;
            hold_fall <= FALL_INIT;
        end else if (wr_en) begin
            hold_rise <= rise_in;
            hold_fall <= fall_in;
        end
    end

    // Promote the held edge counts at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_rise <= RISE_INIT;
            act_fall <= FALL_INIT;
        end else if (frame_end) begin
            act_rise <= hold_rise;
            act_fall <= hold_fall;
        end
    end

    generate
        if (HAS_LIMIT != 0) begin : g_limit
            logic [CNT_W-1:0] hold_limit;
            logic             hold_limit_en;
            logic [CNT_W-1:0] run_limit;
            logic             run_limit_en;

            // Capture host writes into the holding limit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hold_limit    <= CNT_MAX;
                    hold_limit_en <= 1'b0;
                end else if (wr_en) begin
                    hold_limit    <= limit_in;
                    hold_limit_en <= limit_en_in;
                end
            end

            // Promote the held limit at the frame boundary.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    run_limit    <= CNT_MAX;
                    run_limit_en <= 1'b0;
                end else if (frame_end) begin
                    run_limit    <= hold_limit;
                    run_limit_en <= hold_limit_en;
                end
            end

            assign act_limit    = run_limit;
            assign act_limit_en = run_limit_en;
        end else begin : g_no_limit
            logic unused_limit;
            assign unused_limit = ^{limit_in, limit_en_in};
            assign act_limit    = CNT_MAX;
            assign act_limit_en = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pwm_frame_ctr.sv
// Module: pwm_frame_ctr
// Frame counter gated by the prescaler enable. It wraps after the last
// count of the frame (full range, or the limit when enabled) and registers
// a one-clock start-of-frame marker. Assumes the limit only changes on a
// frame end, so the counter never sits above it.
module pwm_frame_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    input  logic             limit_en,
    output logic [CNT_W-1:0] cnt,
    output logic             frame_end,
    output logic             sync
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] last_cnt;
    logic             at_last;

    // Select the final count of the current frame.
    always_comb begin
        last_cnt  = limit_en ? limit : CNT_MAX;
        at_last   = (cnt >= last_cnt);
        frame_end = tick && at_last;
    end

    // Advance or wrap the counter on enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= at_last ? '0 : cnt + 1'b1;
        end
    end

    // Mark the first clock of each new frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync <= 1'b0;
        end else begin
            sync <= frame_end;
        end
    end

endmodule

// File: rtl/pwm_edge_gen.sv
// Module: pwm_edge_gen
// Decides from the counter and the active edge counts whether the pulse is
// high, and registers the result. Assumes the counts change only at frame
// boundaries; the output lags the counter by one clock.
module pwm_edge_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] rise,
    input  logic [CNT_W-1:0] fall,
    output logic             pwm
);

    import phase_pwm_pkg::*;

    pulse_shape_e shape;
    logic         want_high;

    // Classify the pulse and test the counter against its window.
    always_comb begin
        if (rise == fall) begin
            shape = SHAPE_NONE;
        end else if (rise < fall) begin
            shape = SHAPE_INNER;
        end else begin
            shape = SHAPE_SPAN;
        end
        unique case (shape)
            SHAPE_INNER: want_high = (cnt >= rise) && (cnt < fall);
            SHAPE_SPAN:  want_high = (cnt >= rise) || (cnt < fall);
            default:     want_high = 1'b0;
        endcase
    end

    // Register the output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm <= 1'b0;
        end else begin
            pwm <= want_high;
        end
    end

endmodule

// File: rtl/phase_pwm.sv
// Module: phase_pwm
// Top of the phase-offset pulse generator: settings bank, frame counter
// and edge generator. Assumes tick_en comes from an external prescaler and
// that the setting inputs are valid whenever wr_en is high.
module phase_pwm #(
    parameter int CNT_W     = phase_pwm_pkg::DEF_CNT_W,
    parameter int HAS_LIMIT = 1,
    parameter int RISE_RST  = phase_pwm_pkg::DEF_RISE_RST,
    parameter int FALL_RST  = phase_pwm_pkg::DEF_FALL_RST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] rise_cnt,
    input  logic [CNT_W-1:0] fall_cnt,
    input  logic [CNT_W-1:0] limit_cnt,
    input  logic             limit_en,
    output logic             pwm_out,
    output logic             frame_sync
);

    logic [CNT_W-1:0] cnt_q;
    logic             frame_end;
    logic [CNT_W-1:0] act_rise;
    logic [CNT_W-1:0] act_fall;
    logic [CNT_W-1:0] act_limit;
    logic             act_limit_en;

    pwm_cfg_bank #(
        .CNT_W(CNT_W), .HAS_LIMIT(HAS_LIMIT),
        .RISE_RST(RISE_RST), .FALL_RST(FALL_RST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .rise_in(rise_cnt), .fall_in(fall_cnt),
        .limit_in(limit_cnt), .limit_en_in(limit_en),
        .frame_end(frame_end),
        .act_rise(act_rise), .act_fall(act_fall),
        .act_limit(act_limit), .act_limit_en(act_limit_en)
    );

    pwm_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .tick(tick_en),
        .limit(act_limit), .limit_en(act_limit_en),
        .cnt(cnt_q), .frame_end(frame_end), .sync(frame_sync)
    );

    pwm_edge_gen #(.CNT_W(CNT_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .cnt(cnt_q),
        .rise(act_rise), .fall(act_fall), .pwm(pwm_out)
    );

endmodule

// File: rtl/phase_pwm_chk.sv
// Module: phase_pwm_chk
// Property checker bound into phase_pwm; observes the ports and the state
// that the submodules exchange.
module phase_pwm_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             pwm_out,
    input logic             frame_sync,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] act_rise,
    input logic [CNT_W-1:0] act_fall,
    input logic [CNT_W-1:0] act_limit,
    input logic             act_limit_en
);

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt)); // R1

    AST_SYNC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |-> (cnt == '0)); // R5

    AST_EQUAL_EDGES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (act_rise == act_fall) |=> !pwm_out); // R4

    AST_LIMIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        act_limit_en |-> (cnt <= act_limit)); // R6

    AST_SWAP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_rise != $past(act_rise)) || (act_fall != $past(act_fall)))
        |-> (cnt == '0)); // R7

endmodule

bind phase_pwm phase_pwm_chk #(.CNT_W(CNT_W)) u_phase_pwm_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .pwm_out(pwm_out), .frame_sync(frame_sync), .cnt(cnt_q),
    .act_rise(act_rise), .act_fall(act_fall),
    .act_limit(act_limit), .act_limit_en(act_limit_en)
);

// File: tb/test_phase_pwm.sv
// Bench for phase_pwm: a cycle model of the frame counter and double buffer,
// with sweeps over edge pairs on a short frame.
module test_phase_pwm;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] rise_cnt = '0;
    logic [7:0] fall_cnt = '0;
    logic [7:0] limit_cnt = '0;
    logic       limit_en = 1'b0;
    logic       pwm_out;
    logic       frame_sync;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // model state
    int m_cnt = 0;
    int a_rise = 'h32, a_fall = 'h64, a_lim = 255;
    bit a_lim_en = 1'b0;
    int h_rise = 'h32, h_fall = 'h64, h_lim = 255;
    bit h_lim_en = 1'b0;

    always #2 clk = ~clk;

    phase_pwm i_phase_pwm (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .rise_cnt(rise_cnt), .fall_cnt(fall_cnt),
        .limit_cnt(limit_cnt), .limit_en(limit_en),
        .pwm_out(pwm_out), .frame_sync(frame_sync)
    );

    function automatic bit exp_high(int c, int r, int f);
        if (r == f) return 1'b0;
        if (r < f) return (c >= r) && (c < f);
        return (c >= r) || (c < f);
    endfunction

    function automatic int last_of();
        return a_lim_en ? a_lim : 255;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, model the edge, compare at next negedge.
    task automatic step(input bit t, input bit w, input int r, input int f,
                        input int l, input bit le, input string req);
        bit e_out, e_sync;
        tick_en = t; wr_en = w;
        rise_cnt = 8'(r); fall_cnt = 8'(f); limit_cnt = 8'(l); limit_en = le;
        @(posedge clk);
        e_out  = exp_high(m_cnt, a_rise, a_fall);
        e_sync = t && (m_cnt >= last_of());
        if (t) begin
            if (m_cnt >= last_of()) begin
                m_cnt = 0;
                a_rise = h_rise; a_fall = h_fall; a_lim = h_lim; a_lim_en = h_lim_en;
            end else begin
                m_cnt++;
            end
        end
        if (w) begin
            h_rise = r; h_fall = f; h_lim = l; h_lim_en = le;
        end
        @(negedge clk);
        wr_en = 1'b0;
        check(pwm_out == e_out, req, "pwm_out", int'(pwm_out), int'(e_out));
        check(frame_sync == e_sync, "R5", "frame_sync", int'(frame_sync), int'(e_sync));
    endtask

    task automatic run(input int n, input int gap, input string req);
        for (int i = 0; i < n; i++) step((i % gap) == 0, 1'b0, 0, 0, 0, 1'b0, req);
    endtask

    function automatic string shape_tag(int r, int f);
        if (r == f) return "R4";
        if (r < f) return "R2";
        return "R3";
    endfunction

    initial begin
        #800000;
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R8", "pwm_out in reset", int'(pwm_out), 0);
        check(frame_sync == 1'b0, "R8", "frame_sync in reset", int'(frame_sync), 0);
        rst_n = 1'b1;

        // R8 and R1: reset settings over two full 256-tick frames
        run(520, 1, "R8");

        // R1: gated ticks, one in three
        run(800, 3, "R1");

        // R7: mid-frame write of a limited frame, old shape persists until wrap
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 0, 0, 0, 1'b0, "R7");
        step(1'b1, 1'b1, 2, 5, 9, 1'b1, "R7");
        run(300, 1, "R7");

        // R2, R3, R4: every rise/fall pair on a ten-count frame
        for (int r = 0; r < 10; r++) begin
            for (int f = 0; f < 10; f++) begin
                step(1'b1, 1'b1, r, f, 9, 1'b1, shape_tag(r, f));
                run(21, 1, shape_tag(r, f));
            end
        end

        // R6: short frames of every length from 1 to 6 ticks
        for (int l = 0; l < 6; l++) begin
            step(1'b1, 1'b1, 0, 1, l, 1'b1, "R6");
            run(3 * (l + 1) + 12, 2, "R6");
        end

        // R6: exact one-in-five duty, counted over ten settled frames
        begin
            int highs;
            step(1'b1, 1'b1, 0, 1, 4, 1'b1, "R6");
            run(20, 1, "R6");
            highs = 0;
            for (int i = 0; i < 50; i++) begin
                step(1'b1, 1'b0, 0, 0, 0, 1'b0, "R6");
                highs += int'(pwm_out);
            end
            check(highs == 10, "R6", "high cycles in 50", highs, 10);
        end

        // R7: write issued in the frame-ending tick waits one more frame
        for (int k = 0; k < 4; k++) begin
            while (m_cnt != last_of()) step(1'b1, 1'b0, 0, 0, 0, 1'b0, "R7");
            step(1'b1, 1'b1, k + 1, 3 + k, 6 + k, 1'b1, "R7");
            run(30, 1, "R7");
        end

        // R7: write in the last count but without a tick, then tick to wrap
        while (m_cnt != last_of()) step(1'b1, 1'b0, 0, 0, 0, 1'b0, "R7");
        step(1'b0, 1'b1, 7, 2, 11, 1'b1, "R7");
        run(40, 1, "R3");

        // R1: return to full-length frames and check the wrap at 255
        step(1'b1, 1'b1, 250, 3, 0, 1'b0, "R1");
        run(600, 1, "R1");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule